// File: doc/BRIEF.md
# Watermark-Driven Transfer FIFO with Request Control

This block is a 16-entry byte FIFO that sits between a host bus and a disk data path. It also contains the logic that decides when the host side is asked for service. One configuration input selects the direction: bytes flow either from the disk side to the host, or from the host to the disk side. A second configuration input selects how service is requested. In DMA style the request goes out on a DMA request line. In interrupt style it goes out on an interrupt line and on a matching polled status bit. A programmable threshold sets the watermark. A small value lets the host wait longer between requests but requires quick service. A large value gives a slow host more slack but produces more frequent requests.

A transfer phase opens with a one-cycle `exec_start` pulse. This pulse empties the FIFO, clears the error flags and resets the termination state. The disk side uses valid/ready streams. On `disk_in_*`, `disk_in_ready` is high while the FIFO is not full and the direction is disk-to-host; a source must hold a byte until it sees ready. On `disk_out_*`, `disk_out_valid` is high while bytes are waiting in host-to-disk direction. A sink that raises `disk_out_ready` against an empty FIFO is starved, and this is recorded as an underrun. The host side uses single-cycle read and write strobes together with a DMA acknowledge level and a terminal-count level.

A host-to-disk phase ends after a terminal condition has been seen and the disk side has drained the FIFO. The block then emits a one-cycle result-phase pulse and closes the phase.

Top module: `xfer_fifo_ctrl`

## Requirements
- R1: The FIFO holds up to 16 bytes and returns them in arrival order. `host_rdata` and `disk_out_data` show the oldest byte. `disk_in_ready` is low while 16 bytes are held.
- R2: With `cfg_dir`=0 (disk-to-host), the request rises once the registered occupancy is at least 16 − `cfg_thresh`. This is visible two cycles after the push that reaches that level. The request then stays high until occupancy is zero, and it is low again two cycles after the pop that empties the FIFO.
- R3: With `cfg_dir`=0, a byte pushed with `disk_in_last`=1 raises the request even below the watermark, two cycles after that push.
- R4: `cfg_dma_mode`=1 steers the request onto `dma_req`. `cfg_dma_mode`=0 steers it onto both `irq` and `rqm`. `dma_req` and `irq` are never high together.
- R5: With `cfg_dir`=1 (host-to-disk), the request is high one cycle after `exec_start`. It falls when occupancy reaches 16 and rises again when occupancy is at or below `cfg_thresh`; each of these changes appears two cycles after the pop or write that causes it.
- R6: In DMA disk-to-host mode, the final byte is the only byte left after a `disk_in_last` push. While it is held, a rising edge of `dma_ack` or a host read strobe drops the request one cycle later. The request then stays low for the rest of the phase.
- R7: In DMA host-to-disk mode, `tc` high together with either `dma_ack` high or a host write strobe drops the request one cycle later. The request stays low for the rest of the phase.
- R8: In interrupt host-to-disk mode, a falling edge of `tc` while `dma_ack` is low drops `irq` and `rqm` one cycle later and ends the data flow of the phase.
- R9: In host-to-disk direction, once termination (R7 or R8) has occurred and occupancy is zero, `result_enter` pulses high for exactly one cycle. This happens two cycles after the emptying pop, or one cycle after termination if the FIFO is already empty. The phase then closes.
- R10: `underrun` sets one cycle after `disk_out_ready` is high against an empty FIFO during a host-to-disk phase. It stays set until the next `exec_start`.
- R11: `overrun` sets one cycle after either of two events: `disk_in_valid` while the FIFO is full in disk-to-host direction, or a host write strobe while the FIFO is full. The byte is dropped. The flag stays set until the next `exec_start`, which clears both flags.
- R12: Host strobes have no effect outside an open phase, and none against the current direction (a write strobe in disk-to-host, a read strobe in host-to-disk).
- R13: After reset, `dma_req`, `irq`, `rqm`, `result_enter`, `underrun`, `overrun` and `disk_out_valid` are low, and `disk_in_ready` is high with `cfg_dir`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thresh | input | 4 | Watermark threshold |
| cfg_dma_mode | input | 1 | 1 = DMA request style, 0 = interrupt/polled style |
| cfg_dir | input | 1 | 0 = disk-to-host, 1 = host-to-disk |
| exec_start | input | 1 | One-cycle pulse opening a transfer phase |
| disk_in_valid | input | 1 | Disk source has a byte |
| disk_in_data | input | 8 | Disk source byte |
| disk_in_last | input | 1 | Byte closes a full sector |
| disk_in_ready | output | 1 | FIFO accepts a disk byte |
| disk_out_valid | output | 1 | Byte available for the disk sink |
| disk_out_data | output | 8 | Oldest byte for the disk sink |
| disk_out_ready | input | 1 | Disk sink takes a byte |
| host_wr_stb | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rd_stb | input | 1 | Host read strobe, pops one byte |
| host_rdata | output | 8 | Oldest byte for the host |
| dma_ack | input | 1 | DMA acknowledge, active high |
| tc | input | 1 | Terminal count, active high |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt request |
| rqm | output | 1 | Polled request-for-master status |
| result_enter | output | 1 | One-cycle pulse entering result phase |
| underrun | output | 1 | Sticky disk-side starvation flag |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
Each result has a fixed latency. `exec_start`, every push and pop, both flags, and the last-byte and terminal-count releases all take effect at the first clock edge after the stimulus. Requests driven by the watermark, the empty level or the full level come one edge later, because they compare the registered occupancy. `result_enter` comes two edges after the pop that empties the FIFO. The bench drives every input just after a falling edge and reads outputs at later falling edges counted to those exact latencies. It also checks the cycle before each due change, so a result that arrives early or late is caught.

// File: rtl/tfr_pkg.sv
`timescale 1ns/1ps
package tfr_pkg;
  typedef enum logic {
    DIR_TO_HOST = 1'b0,
    DIR_TO_DISK = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/tfr_fifo.sv
`timescale 1ns/1ps
module tfr_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] slot_vec [DEPTH];
  logic          do_push, do_pop;

  assign full    = (occ == CW'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // one register per slot, written only when the write pointer selects it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (!flush && do_push && wr_ptr == AW'(i))
        slot_q <= wdata;
    end
    assign slot_vec[i] = slot_q;
  end

  assign head = slot_vec[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/tfr_req_ctrl.sv
`timescale 1ns/1ps
module tfr_req_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_start,
  input  logic          dir_to_disk,
  input  logic          dma_mode,
  input  logic [TW-1:0] thresh,
  input  logic [CW-1:0] occ,
  input  logic          load_last,
  input  logic          host_rd_evt,
  input  logic          host_wr_evt,
  input  logic          dma_ack,
  input  logic          tc,
  output logic          req,
  output logic          exec_active,
  output logic          result_enter
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic req_q, req_d;
  logic done_q, done_d;
  logic exec_q, exec_d;
  logic res_q, res_d;
  logic last_q, last_d;
  logic ack_q, tc_q;

  logic          ack_rise, tc_fall;
  logic [CW-1:0] mark;
  logic          at_mark, low_water, is_empty, is_full, rd_final;

  assign ack_rise  = dma_ack & ~ack_q;
  assign tc_fall   = tc_q & ~tc;
  assign mark      = DEPTH_C - CW'(thresh);
  assign at_mark   = (occ >= mark);
  assign low_water = (occ <= CW'(thresh));
  assign is_empty  = (occ == '0);
  assign is_full   = (occ == DEPTH_C);
  assign rd_final  = last_q && (occ == CW'(1));

  always_comb begin
    req_d  = req_q;
    done_d = done_q;
    exec_d = exec_q;
    res_d  = 1'b0;
    last_d = last_q | load_last;
    if (exec_start) begin
      req_d  = dir_to_disk;
      done_d = 1'b0;
      exec_d = 1'b1;
      last_d = 1'b0;
    end else if (!exec_q) begin
      req_d = 1'b0;
    end else if (!dir_to_disk) begin
      // disk-to-host: raise at watermark or sector end, release at empty
      if (done_q || is_empty) begin
        req_d = 1'b0;
      end else if (dma_mode && rd_final && (ack_rise || host_rd_evt)) begin
        req_d  = 1'b0;
        done_d = 1'b1;
      end else if (at_mark || last_q) begin
        req_d = 1'b1;
      end
    end else begin
      // host-to-disk: release at full or termination, rearm at low water
      if (dma_mode && tc && (dma_ack || host_wr_evt)) begin
        req_d  = 1'b0;
        done_d = 1'b1;
      end else if (!dma_mode && tc_fall && !dma_ack) begin
        req_d  = 1'b0;
        done_d = 1'b1;
      end else if (done_q || is_full) begin
        req_d = 1'b0;
      end else if (low_water) begin
        req_d = 1'b1;
      end
      if (done_q && is_empty) begin
        req_d  = 1'b0;
        exec_d = 1'b0;
        res_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      exec_q <= 1'b0;
      res_q  <= 1'b0;
      last_q <= 1'b0;
      ack_q  <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      req_q  <= req_d;
      done_q <= done_d;
      exec_q <= exec_d;
      res_q  <= res_d;
      last_q <= last_d;
      ack_q  <= dma_ack;
      tc_q   <= tc;
    end
  end

  assign req          = req_q;
  assign exec_active  = exec_q;
  assign result_enter = res_q;
endmodule

// File: rtl/tfr_fault_flags.sv
`timescale 1ns/1ps
module tfr_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic starve_evt,
  input  logic spill_evt,
  output logic underrun,
  output logic overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else if (clear) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      underrun <= underrun | starve_evt;
      overrun  <= overrun | spill_evt;
    end
  end
endmodule

// File: rtl/xfer_fifo_ctrl.sv
`timescale 1ns/1ps
module xfer_fifo_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_thresh,
  input  logic          cfg_dma_mode,
  input  logic          cfg_dir,
  input  logic          exec_start,
  input  logic          disk_in_valid,
  input  logic [DW-1:0] disk_in_data,
  input  logic          disk_in_last,
  output logic          disk_in_ready,
  output logic          disk_out_valid,
  output logic [DW-1:0] disk_out_data,
  input  logic          disk_out_ready,
  input  logic          host_wr_stb,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd_stb,
  output logic [DW-1:0] host_rdata,
  input  logic          dma_ack,
  input  logic          tc,
  output logic          dma_req,
  output logic          irq,
  output logic          rqm,
  output logic          result_enter,
  output logic          underrun,
  output logic          overrun
);
  import tfr_pkg::*;

  xfer_dir_e     dir_sel;
  logic          to_disk;
  logic [CW-1:0] occ;
  logic          fifo_full, fifo_empty;
  logic [DW-1:0] head;
  logic          exec_q, req;
  logic          disk_push, host_push, disk_pop, host_pop;
  logic          host_wr_evt, host_rd_evt;
  logic          push, pop;
  logic [DW-1:0] push_data;
  logic          starve_evt, spill_evt;

  assign dir_sel = xfer_dir_e'(cfg_dir);
  assign to_disk = (dir_sel == DIR_TO_DISK);

  // host strobes count only inside a phase and in their own direction
  assign host_wr_evt = host_wr_stb & exec_q & to_disk;
  assign host_rd_evt = host_rd_stb & exec_q & ~to_disk;

  assign disk_in_ready  = ~fifo_full & ~to_disk;
  assign disk_out_valid = ~fifo_empty & to_disk;
  assign disk_push      = disk_in_valid & disk_in_ready;
  assign disk_pop       = disk_out_valid & disk_out_ready;
  assign host_push      = host_wr_evt & ~fifo_full;
  assign host_pop       = host_rd_evt & ~fifo_empty;

  assign push      = to_disk ? host_push : disk_push;
  assign pop       = to_disk ? disk_pop : host_pop;
  assign push_data = to_disk ? host_wdata : disk_in_data;

  assign starve_evt = exec_q & to_disk & disk_out_ready & fifo_empty;
  assign spill_evt  = (disk_in_valid & ~to_disk & fifo_full) | (host_wr_evt & fifo_full);

  tfr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (exec_start),
    .push  (push),
    .wdata (push_data),
    .pop   (pop),
    .head  (head),
    .occ   (occ),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  tfr_req_ctrl #(.DEPTH(DEPTH)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_start   (exec_start),
    .dir_to_disk  (to_disk),
    .dma_mode     (cfg_dma_mode),
    .thresh       (cfg_thresh),
    .occ          (occ),
    .load_last    (disk_push & disk_in_last),
    .host_rd_evt  (host_rd_evt),
    .host_wr_evt  (host_wr_evt),
    .dma_ack      (dma_ack),
    .tc           (tc),
    .req          (req),
    .exec_active  (exec_q),
    .result_enter (result_enter)
  );

  tfr_fault_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (exec_start),
    .starve_evt (starve_evt),
    .spill_evt  (spill_evt),
    .underrun   (underrun),
    .overrun    (overrun)
  );

  assign disk_out_data = head;
  assign host_rdata    = head;
  assign dma_req       = req & cfg_dma_mode;
  assign irq           = req & ~cfg_dma_mode;
  assign rqm           = req & ~cfg_dma_mode;
endmodule

// File: rtl/xfer_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module xfer_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dir,
  input logic          exec_start,
  input logic          exec_active,
  input logic          dma_req,
  input logic          irq,
  input logic          underrun,
  input logic          overrun,
  input logic          result_enter,
  input logic [CW-1:0] occ
);
  logic req_any;
  assign req_any = dma_req | irq;

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_read_empty_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && !cfg_dir && occ == '0 && !exec_start) |=> !req_any);

  assert_single_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq));

  assert_write_start_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && cfg_dir) |=> req_any);

  assert_write_full_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && cfg_dir && occ == CW'(DEPTH) && !exec_start) |=> !req_any);

  assert_result_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_enter |-> (occ == '0 && !exec_active));

  assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_enter && !exec_start) |=> !result_enter);

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !exec_start) |=> underrun);

  assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !exec_start) |=> overrun);

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> (!underrun && !overrun && occ == '0));
endmodule

bind xfer_fifo_ctrl xfer_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dir      (cfg_dir),
  .exec_start   (exec_start),
  .exec_active  (exec_q),
  .dma_req      (dma_req),
  .irq          (irq),
  .underrun     (underrun),
  .overrun      (overrun),
  .result_enter (result_enter),
  .occ          (occ)
);

// File: tb/xfer_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module xfer_fifo_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_thresh = 4'd4;
  logic       cfg_dma_mode = 1'b0;
  logic       cfg_dir = 1'b0;
  logic       exec_start = 1'b0;
  logic       disk_in_valid = 1'b0;
  logic [7:0] disk_in_data = '0;
  logic       disk_in_last = 1'b0;
  logic       disk_in_ready;
  logic       disk_out_valid;
  logic [7:0] disk_out_data;
  logic       disk_out_ready = 1'b0;
  logic       host_wr_stb = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd_stb = 1'b0;
  logic [7:0] host_rdata;
  logic       dma_ack = 1'b0;
  logic       tc = 1'b0;
  logic       dma_req, irq, rqm, result_enter, underrun, overrun;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  xfer_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_dma_mode(cfg_dma_mode),
    .cfg_dir(cfg_dir), .exec_start(exec_start), .disk_in_valid(disk_in_valid),
    .disk_in_data(disk_in_data), .disk_in_last(disk_in_last), .disk_in_ready(disk_in_ready),
    .disk_out_valid(disk_out_valid), .disk_out_data(disk_out_data),
    .disk_out_ready(disk_out_ready), .host_wr_stb(host_wr_stb), .host_wdata(host_wdata),
    .host_rd_stb(host_rd_stb), .host_rdata(host_rdata), .dma_ack(dma_ack), .tc(tc),
    .dma_req(dma_req), .irq(irq), .rqm(rqm), .result_enter(result_enter),
    .underrun(underrun), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_phase(input logic dir, input logic mode, input logic [3:0] thr);
    cfg_dir = dir; cfg_dma_mode = mode; cfg_thresh = thr;
    exec_start = 1'b1; step(1); exec_start = 1'b0;
  endtask

  task automatic disk_push(input logic [7:0] d, input logic last);
    disk_in_valid = 1'b1; disk_in_data = d; disk_in_last = last;
    step(1);
    disk_in_valid = 1'b0; disk_in_last = 1'b0;
  endtask

  task automatic host_read(input string tag, input logic [7:0] exp);
    chk(tag, host_rdata, exp);
    host_rd_stb = 1'b1; step(1); host_rd_stb = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wdata = d; host_wr_stb = 1'b1; step(1); host_wr_stb = 1'b0;
  endtask

  task automatic disk_pop(input string tag, input logic [7:0] exp);
    chk(tag, disk_out_data, exp);
    disk_out_ready = 1'b1; step(1); disk_out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 dma_req", dma_req, 0);
    chk("R13 irq", irq, 0);
    chk("R13 rqm", rqm, 0);
    chk("R13 result_enter", result_enter, 0);
    chk("R13 underrun", underrun, 0);
    chk("R13 overrun", overrun, 0);
    chk("R13 disk_out_valid", disk_out_valid, 0);
    chk("R13 disk_in_ready", disk_in_ready, 1);
  endtask

  task automatic t_read_watermark();
    open_phase(1'b0, 1'b1, 4'd4);
    for (int i = 0; i < 11; i++) disk_push(8'h10 + 8'(i), 1'b0);
    step(2);
    chk("R2 below mark", dma_req, 0);
    disk_push(8'h1B, 1'b0);
    chk("R2 mark not yet", dma_req, 0);
    step(1);
    chk("R2 mark reached", dma_req, 1);
    chk("R4 dma steers off irq", irq, 0);
    chk("R4 dma steers off rqm", rqm, 0);
    for (int i = 0; i < 11; i++) host_read("R1 order", 8'h10 + 8'(i));
    chk("R2 held until empty", dma_req, 1);
    host_read("R1 order last", 8'h1B);
    chk("R2 held one cycle", dma_req, 1);
    step(1);
    chk("R2 empty release", dma_req, 0);
  endtask

  task automatic t_sector_end_irq();
    open_phase(1'b0, 1'b0, 4'd4);
    disk_push(8'hA1, 1'b0);
    disk_push(8'hA2, 1'b0);
    disk_push(8'hA3, 1'b1);
    chk("R3 not yet", irq, 0);
    step(1);
    chk("R3 sector end irq", irq, 1);
    chk("R4 rqm follows", rqm, 1);
    chk("R4 no dma_req", dma_req, 0);
    host_read("R1 a1", 8'hA1);
    host_read("R1 a2", 8'hA2);
    host_read("R1 a3", 8'hA3);
    chk("R3 irq until empty", irq, 1);
    step(1);
    chk("R3 irq empty release", irq, 0);
  endtask

  task automatic t_dma_read_last();
    open_phase(1'b0, 1'b1, 4'd4);
    disk_push(8'hB1, 1'b0);
    disk_push(8'hB2, 1'b1);
    step(1);
    chk("R6 request up", dma_req, 1);
    host_read("R6 b1", 8'hB1);
    dma_ack = 1'b1;
    step(1);
    chk("R6 ack edge release", dma_req, 0);
    chk("R6 byte still held", host_rdata, 8'hB2);
    step(2);
    chk("R6 stays low", dma_req, 0);
    dma_ack = 1'b0;
    host_read("R6 b2", 8'hB2);
    chk("R6 low after read", dma_req, 0);
    open_phase(1'b0, 1'b1, 4'd4);
    disk_push(8'hC1, 1'b1);
    step(1);
    chk("R6 request up single", dma_req, 1);
    host_read("R6 c1", 8'hC1);
    chk("R6 strobe release", dma_req, 0);
  endtask

  task automatic t_write_dma();
    open_phase(1'b1, 1'b1, 4'd4);
    chk("R5 request on start", dma_req, 1);
    for (int i = 0; i < 16; i++) host_write(8'h30 + 8'(i));
    chk("R5 held at 15 compare", dma_req, 1);
    step(1);
    chk("R5 full release", dma_req, 0);
    host_write(8'hEE);
    chk("R11 host overrun", overrun, 1);
    for (int i = 0; i < 11; i++) disk_pop("R1 write order", 8'h30 + 8'(i));
    step(1);
    chk("R5 above threshold", dma_req, 0);
    disk_pop("R1 write order", 8'h3B);
    chk("R5 rearm not yet", dma_req, 0);
    step(1);
    chk("R5 rearm at threshold", dma_req, 1);
    tc = 1'b1; dma_ack = 1'b1;
    step(1);
    chk("R7 tc with ack release", dma_req, 0);
    tc = 1'b0; dma_ack = 1'b0;
    step(2);
    chk("R7 stays low", dma_req, 0);
    for (int i = 12; i < 16; i++) disk_pop("R1 write order", 8'h30 + 8'(i));
    chk("R9 not yet", result_enter, 0);
    step(1);
    chk("R9 result pulse", result_enter, 1);
    step(1);
    chk("R9 single cycle", result_enter, 0);
    host_write(8'h77);
    chk("R12 write after phase ignored", disk_out_valid, 0);
    chk("R11 overrun sticky", overrun, 1);
  endtask

  task automatic t_write_tc_strobe();
    open_phase(1'b1, 1'b1, 4'd4);
    tc = 1'b1;
    host_write(8'h5A);
    tc = 1'b0;
    chk("R7 tc with strobe release", dma_req, 0);
    chk("R7 byte taken", disk_out_valid, 1);
    step(2);
    chk("R7 stays low strobe", dma_req, 0);
    disk_pop("R7 data", 8'h5A);
    step(1);
    chk("R9 result after drain", result_enter, 1);
  endtask

  task automatic t_write_irq_tc();
    open_phase(1'b1, 1'b0, 4'd4);
    chk("R5 irq on start", irq, 1);
    chk("R4 rqm on start", rqm, 1);
    chk("R4 no dma_req write", dma_req, 0);
    tc = 1'b1;
    step(1);
    chk("R8 tc high keeps irq", irq, 1);
    tc = 1'b0;
    step(1);
    chk("R8 tc fall release", irq, 0);
    step(1);
    chk("R9 result already empty", result_enter, 1);
  endtask

  task automatic t_underrun();
    open_phase(1'b1, 1'b1, 4'd4);
    chk("R10 clear at start", underrun, 0);
    disk_out_ready = 1'b1;
    step(1);
    disk_out_ready = 1'b0;
    chk("R10 underrun set", underrun, 1);
    step(3);
    chk("R10 underrun sticky", underrun, 1);
    open_phase(1'b1, 1'b1, 4'd4);
    chk("R10 cleared by start", underrun, 0);
  endtask

  task automatic t_disk_overrun();
    open_phase(1'b0, 1'b1, 4'd4);
    chk("R11 cleared by start", overrun, 0);
    for (int i = 0; i < 16; i++) disk_push(8'hE0 + 8'(i), 1'b0);
    chk("R1 ready low when full", disk_in_ready, 0);
    disk_push(8'hFF, 1'b0);
    chk("R11 disk overrun", overrun, 1);
    for (int i = 0; i < 16; i++) host_read("R11 data intact", 8'hE0 + 8'(i));
    chk("R11 still set", overrun, 1);
  endtask

  task automatic t_wrong_direction();
    open_phase(1'b0, 1'b0, 4'd15);
    disk_push(8'hF1, 1'b0);
    host_write(8'h99);
    step(1);
    chk("R12 irq at mark", irq, 1);
    host_read("R12 oldest byte", 8'hF1);
    step(2);
    chk("R12 wrong-direction write ignored", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_read_watermark();
    t_sector_end_irq();
    t_dma_read_last();
    t_write_dma();
    t_write_tc_strobe();
    t_write_irq_tc();
    t_underrun();
    t_disk_overrun();
    t_wrong_direction();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule